// File: doc/BRIEF.md
# Register Readiness Wakeup Tracker

This block keeps one ready bit for every physical register and a small table of waiting instructions. The register space covers the integer physical registers and the floating-point physical registers together. When an instruction enters a table slot, each of its source operands is resolved against the scoreboard. A source is treated as already satisfied if any of these holds:

- the caller flags it as ready;
- the scoreboard says its register is ready;
- a completion of that register arrives in the same cycle;
- its tag lies outside the tracked range.

Any other source waits on its register tag. The destination registers the instruction claims are marked not ready.

When a producer finishes, its destination tag is broadcast on the completion port. Every waiting source with that tag becomes ready and the register's scoreboard bit is set. In the same cycle, a wake mask names each slot whose last outstanding source this completion satisfies. A squash mask removes slots, and with them their waiting sources. Claiming a register that still has waiting sources is an inconsistency, and the block reports it on an error flag. Choosing which ready slot to issue, execution units and memory ordering are left to neighbouring logic.

Top module: `reg_wakeup_tracker`

## Requirements
- R1: After reset every register in the tracked range is not ready, so a slot inserted with an unready source on any tracked tag stays out of `ready_vec` until that tag completes.
- R2: An insert with `ins_dst_vld` set marks its tracked destination register not ready. A later insert with an unready source on that tag is not ready.
- R3: An insert whose source is flagged unready, but whose register is already ready in the scoreboard, treats that source as ready. It is not added as a waiter, and the slot appears in `ready_vec` one cycle after the insert.
- R4: In a cycle with `cmp_vld` set, `wake_vec` bit e is set for each valid slot e that is not squashed or reloaded this cycle, is not yet ready, and has every unready source tagged `cmp_tag`. The cycle after, those slots are in `ready_vec`, and the register reads as ready for later inserts.
- R5: An insert whose unready source tag equals the `cmp_tag` of a completion in the same cycle treats that source as ready.
- R6: The tracked range is tags 0 to INT_REGS+FP_REGS-1. Source tags at or above it are treated as ready. Destination tags at or above it change no scoreboard bit and never raise `claim_err`. The highest tracked tag is tracked normally.
- R7: `claim_err` is high in the cycle of an insert that claims a tracked destination on which some valid slot still waits. A slot does not count if it is squashed or overwritten in that cycle. The wait does not count if a completion of the same tag arrives in that cycle.
- R8: Squashing slot e (bit e of `sq_mask`) removes it from `ready_vec` in the next cycle. Its waiting sources are dropped: a later completion does not wake it, and a later claim of its tags raises no error.
- R9: `ready_vec` bit e is high exactly when slot e holds an instruction whose NSRC source-ready bits are all set.
- R10: When a completion and a destination claim name the same register in the same cycle, the claim wins and the register is left not ready.
- R11: An insert into slot e in the same cycle as a squash of slot e loads the new instruction; the squash applies only to the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_vld | input | 1 | Insert an instruction this cycle |
| ins_idx | input | $clog2(ENTRIES) | Table slot written by the insert |
| ins_src_tag | input | NSRC*TAG_W | Source register tags, source s in bits s*TAG_W upward |
| ins_src_rdy | input | NSRC | Per-source ready flag given by the caller |
| ins_dst_vld | input | NDST | Per-destination claim enable |
| ins_dst_tag | input | NDST*TAG_W | Destination register tags, packed like sources |
| cmp_vld | input | 1 | A producer completes this cycle |
| cmp_tag | input | TAG_W | Destination tag of the completing producer |
| sq_mask | input | ENTRIES | Slots to squash this cycle |
| ready_vec | output | ENTRIES | Slots whose sources are all ready |
| wake_vec | output | ENTRIES | Slots the current completion makes ready |
| claim_err | output | 1 | Insert claims a register that still has waiters |

## Verification
A wrong scoreboard bit stays hidden until an instruction is inserted with an unready source on that tag. It then shows on `ready_vec` one cycle after that insert, as a slot ready too early or stuck waiting. A lost or stale waiter shows in the cycle of the matching completion, as a wrong `wake_vec` bit. It also shows in the cycle of a later claim of that tag, as a missing or spurious `claim_err`. The bench keeps its own scoreboard and slot model and compares all three outputs in every cycle, so a divergence is caught in the first cycle it becomes visible.

// File: rtl/rwt_pkg.sv
package rwt_pkg;
  // True when a register tag lies inside the tracked physical space.
  function automatic logic tag_tracked(input int tag, input int nreg);
    return (tag >= 0) && (tag < nreg);
  endfunction

  // A source stops waiting when any readiness path covers it.
  function automatic logic src_satisfied(input logic given_rdy, input logic out_of_range,
                                         input logic sb_rdy, input logic same_cycle_cmp);
    return given_rdy | out_of_range | sb_rdy | same_cycle_cmp;
  endfunction
endpackage

// File: rtl/rwt_scoreboard.sv
module rwt_scoreboard #(
  parameter int NREG  = 32,
  parameter int TAG_W = 6,
  parameter int NDST  = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  set_vld,
  input  logic [TAG_W-1:0]      set_tag,
  input  logic [NDST-1:0]       clr_vld,
  input  logic [NDST*TAG_W-1:0] clr_tags,
  output logic [NREG-1:0]       sb_q
);
  logic [NREG-1:0] sb_d;
  logic [NREG-1:0] set_hit;
  logic [NREG-1:0] clr_hit;

  always_comb begin
    set_hit = '0;
    clr_hit = '0;
    for (int r = 0; r < NREG; r++) begin
      if (set_vld && set_tag == TAG_W'(r)) set_hit[r] = 1'b1;
      for (int d = 0; d < NDST; d++)
        if (clr_vld[d] && clr_tags[d*TAG_W +: TAG_W] == TAG_W'(r)) clr_hit[r] = 1'b1;
    end
    // A claim takes priority over a same-cycle completion of the register.
    sb_d = (sb_q | set_hit) & ~clr_hit;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sb_q <= '0;
    else        sb_q <= sb_d;
  end

  for (genvar r = 0; r < NREG; r++) begin : g_sb_chk
    assert_cmp_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (set_vld && set_tag == TAG_W'(r) && !clr_hit[r]) |=> sb_q[r]);
    for (genvar d = 0; d < NDST; d++) begin : g_dst
      // Also covers R10: the claim wins over a completion in the same cycle.
      assert_claim_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vld[d] && clr_tags[d*TAG_W +: TAG_W] == TAG_W'(r)) |=> !sb_q[r]);
    end
  end
endmodule

// File: rtl/rwt_entry.sv
module rwt_entry #(
  parameter int NSRC  = 2,
  parameter int TAG_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [NSRC*TAG_W-1:0] load_tags,
  input  logic [NSRC-1:0]       load_rdy,
  input  logic                  kill,
  input  logic                  cmp_vld,
  input  logic [TAG_W-1:0]      cmp_tag,
  output logic                  valid_q,
  output logic [NSRC-1:0]       rdy_q,
  output logic [NSRC*TAG_W-1:0] tags_q,
  output logic [NSRC-1:0]       hit
);
  // A source is hit when it still waits and its tag is being broadcast.
  always_comb begin
    for (int s = 0; s < NSRC; s++)
      hit[s] = valid_q && !rdy_q[s] && cmp_vld && (tags_q[s*TAG_W +: TAG_W] == cmp_tag);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      rdy_q   <= '0;
      tags_q  <= '0;
    end else if (load) begin
      valid_q <= 1'b1;
      rdy_q   <= load_rdy;
      tags_q  <= load_tags;
    end else begin
      if (kill) valid_q <= 1'b0;
      rdy_q <= rdy_q | hit;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_src_chk
    assert_hit_marks_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[s] && !load) |=> rdy_q[s]);
  end
  assert_kill_drops_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (kill && !load) |=> !valid_q);
  assert_load_sets_R11: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> valid_q);
endmodule

// File: rtl/reg_wakeup_tracker.sv
module reg_wakeup_tracker
  import rwt_pkg::*;
#(
  parameter int INT_REGS = 24,
  parameter int FP_REGS  = 8,
  parameter int TAG_W    = 6,
  parameter int ENTRIES  = 8,
  parameter int NSRC     = 2,
  parameter int NDST     = 1,
  localparam int IDX_W   = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_vld,
  input  logic [IDX_W-1:0]      ins_idx,
  input  logic [NSRC*TAG_W-1:0] ins_src_tag,
  input  logic [NSRC-1:0]       ins_src_rdy,
  input  logic [NDST-1:0]       ins_dst_vld,
  input  logic [NDST*TAG_W-1:0] ins_dst_tag,
  input  logic                  cmp_vld,
  input  logic [TAG_W-1:0]      cmp_tag,
  input  logic [ENTRIES-1:0]    sq_mask,
  output logic [ENTRIES-1:0]    ready_vec,
  output logic [ENTRIES-1:0]    wake_vec,
  output logic                  claim_err
);
  localparam int NREG = INT_REGS + FP_REGS;

  logic [NREG-1:0]                       sb_q;
  logic [NSRC-1:0]                       res_rdy;
  logic [NDST-1:0]                       clr_vld;
  logic [NDST-1:0]                       dst_conflict;
  logic [ENTRIES-1:0]                    ent_load;
  logic [ENTRIES-1:0]                    ent_vld;
  logic [ENTRIES-1:0][NSRC-1:0]          ent_rdy;
  logic [ENTRIES-1:0][NSRC-1:0]          ent_hit;
  logic [ENTRIES-1:0][NSRC*TAG_W-1:0]    ent_tags;

  // Resolve each incoming source against the scoreboard and the live broadcast.
  always_comb begin
    logic [TAG_W-1:0] t;
    logic             sb_bit;
    for (int s = 0; s < NSRC; s++) begin
      t      = ins_src_tag[s*TAG_W +: TAG_W];
      sb_bit = 1'b0;
      for (int r = 0; r < NREG; r++)
        if (t == TAG_W'(r) && sb_q[r]) sb_bit = 1'b1;
      res_rdy[s] = src_satisfied(ins_src_rdy[s], !tag_tracked(int'(t), NREG), sb_bit,
                                 cmp_vld && (cmp_tag == t));
    end
  end

  always_comb begin
    for (int d = 0; d < NDST; d++) clr_vld[d] = ins_vld && ins_dst_vld[d];
  end

  rwt_scoreboard #(.NREG(NREG), .TAG_W(TAG_W), .NDST(NDST)) i_sb (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_vld  (cmp_vld),
    .set_tag  (cmp_tag),
    .clr_vld  (clr_vld),
    .clr_tags (ins_dst_tag),
    .sb_q     (sb_q)
  );

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    assign ent_load[e] = ins_vld && (ins_idx == IDX_W'(e));

    rwt_entry #(.NSRC(NSRC), .TAG_W(TAG_W)) i_ent (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (ent_load[e]),
      .load_tags (ins_src_tag),
      .load_rdy  (res_rdy),
      .kill      (sq_mask[e]),
      .cmp_vld   (cmp_vld),
      .cmp_tag   (cmp_tag),
      .valid_q   (ent_vld[e]),
      .rdy_q     (ent_rdy[e]),
      .tags_q    (ent_tags[e]),
      .hit       (ent_hit[e])
    );

    assign ready_vec[e] = ent_vld[e] && (&ent_rdy[e]);
    assign wake_vec[e]  = ent_vld[e] && !(&ent_rdy[e]) && (&(ent_rdy[e] | ent_hit[e]))
                          && !sq_mask[e] && !ent_load[e];

    assert_wake_then_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wake_vec[e] |=> ready_vec[e]);
    assert_squash_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sq_mask[e] && !ent_load[e]) |=> !ready_vec[e]);
    assert_insert_resolved_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ent_load[e] && (&res_rdy)) |=> ready_vec[e]);
  end

  // A claimed register must have no surviving waiters.
  always_comb begin
    logic [TAG_W-1:0] dt;
    dst_conflict = '0;
    for (int d = 0; d < NDST; d++) begin
      dt = ins_dst_tag[d*TAG_W +: TAG_W];
      for (int e = 0; e < ENTRIES; e++)
        for (int s = 0; s < NSRC; s++)
          if (ent_vld[e] && !ent_rdy[e][s] && !sq_mask[e] && !ent_load[e] &&
              ent_tags[e][s*TAG_W +: TAG_W] == dt && !(cmp_vld && cmp_tag == dt) &&
              tag_tracked(int'(dt), NREG))
            dst_conflict[d] = 1'b1;
    end
  end

  assign claim_err = |(clr_vld & dst_conflict);

  assert_err_needs_claim_R7: assert property (@(posedge clk) disable iff (!rst_n)
    claim_err |-> (ins_vld && (|ins_dst_vld)));
endmodule

// File: tb/test_reg_wakeup_tracker.sv
`timescale 1ns/1ps
module test_reg_wakeup_tracker;
  localparam int E  = 8;
  localparam int NS = 2;
  localparam int NR = 32;
  localparam int TW = 6;

  logic clk = 1'b0;
  logic rst_n;
  logic ins_vld;
  logic [2:0] ins_idx;
  logic [NS*TW-1:0] ins_src_tag;
  logic [NS-1:0] ins_src_rdy;
  logic [0:0] ins_dst_vld;
  logic [TW-1:0] ins_dst_tag;
  logic cmp_vld;
  logic [TW-1:0] cmp_tag;
  logic [E-1:0] sq_mask;
  logic [E-1:0] ready_vec, wake_vec;
  logic claim_err;

  int nchecks = 0;
  int nerrors = 0;
  bit done = 0;

  bit m_sb [NR];
  bit m_v  [E];
  bit m_r  [E][NS];
  int m_t  [E][NS];

  always #2.5 clk = ~clk;

  reg_wakeup_tracker i_reg_wakeup_tracker (
    .clk(clk), .rst_n(rst_n), .ins_vld(ins_vld), .ins_idx(ins_idx),
    .ins_src_tag(ins_src_tag), .ins_src_rdy(ins_src_rdy), .ins_dst_vld(ins_dst_vld),
    .ins_dst_tag(ins_dst_tag), .cmp_vld(cmp_vld), .cmp_tag(cmp_tag), .sq_mask(sq_mask),
    .ready_vec(ready_vec), .wake_vec(wake_vec), .claim_err(claim_err)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchecks++;
    if (act != exp) begin
      nerrors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle();
    ins_vld = 0; ins_idx = 0; ins_src_tag = 0; ins_src_rdy = 0;
    ins_dst_vld = 0; ins_dst_tag = 0; cmp_vld = 0; cmp_tag = 0; sq_mask = 0;
  endtask

  task automatic ins(input int idx, input int t0, input bit r0, input int t1, input bit r1,
                     input bit dv, input int dt);
    ins_vld = 1; ins_idx = 3'(idx);
    ins_src_tag = {TW'(t1), TW'(t0)}; ins_src_rdy = {r1, r0};
    ins_dst_vld = dv; ins_dst_tag = TW'(dt);
  endtask

  function automatic int stag(int s);
    return int'(ins_src_tag[s*TW +: TW]);
  endfunction

  // Checks all outputs against the model, advances the model, returns at next negedge.
  task automatic step();
    bit er [E]; bit ew [E]; bit ee; bit hit [E][NS]; bit nr [NS];
    bit all_r, all_h;
    int dt, ct;
    #1;
    ct = int'(cmp_tag); dt = int'(ins_dst_tag); ee = 0;
    for (int e = 0; e < E; e++) begin
      all_r = 1; all_h = 1;
      for (int s = 0; s < NS; s++) begin
        hit[e][s] = m_v[e] && !m_r[e][s] && cmp_vld && m_t[e][s] == ct;
        all_r &= m_r[e][s];
        all_h &= (m_r[e][s] | hit[e][s]);
        if (ins_vld && ins_dst_vld[0] && dt < NR && m_v[e] && !m_r[e][s] && !sq_mask[e] &&
            !(int'(ins_idx) == e) && m_t[e][s] == dt && !(cmp_vld && ct == dt)) ee = 1;
      end
      er[e] = m_v[e] && all_r;
      ew[e] = m_v[e] && !all_r && all_h && !sq_mask[e] && !(ins_vld && int'(ins_idx) == e);
    end
    for (int e = 0; e < E; e++) begin
      chk("R9 ready_vec bit", ready_vec[e], er[e]);
      chk("R4 wake_vec bit", wake_vec[e], ew[e]);
    end
    chk("R7 claim_err", claim_err, ee);
    for (int s = 0; s < NS; s++)
      nr[s] = ins_src_rdy[s] || stag(s) >= NR || m_sb[stag(s) % NR] || (cmp_vld && ct == stag(s));
    if (cmp_vld && ct < NR) m_sb[ct] = 1;
    if (ins_vld && ins_dst_vld[0] && dt < NR) m_sb[dt] = 0;
    for (int e = 0; e < E; e++) begin
      if (ins_vld && int'(ins_idx) == e) begin
        m_v[e] = 1;
        for (int s = 0; s < NS; s++) begin m_r[e][s] = nr[s]; m_t[e][s] = stag(s); end
      end else begin
        if (sq_mask[e]) m_v[e] = 0;
        for (int s = 0; s < NS; s++) m_r[e][s] |= hit[e][s];
      end
    end
    @(negedge clk);
    idle();
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nerrors, nchecks);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      nerrors++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(20240611);
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 reset ready_vec", ready_vec, 0);
    chk("R1 reset wake_vec", wake_vec, 0);
    rst_n = 1;
    for (int r = 0; r < NR; r++) m_sb[r] = 0;
    for (int e = 0; e < E; e++) begin
      m_v[e] = 0;
      for (int s = 0; s < NS; s++) begin m_r[e][s] = 0; m_t[e][s] = 0; end
    end

    // R1: register untouched since reset is not ready
    ins(0, 3, 0, 4, 1, 0, 0); step();
    chk("R1 slot0 waits on untouched reg", ready_vec[0], 0);
    // R4: completion wakes slot 0
    cmp_vld = 1; cmp_tag = 3; #1 chk("R4 wake slot0", wake_vec[0], 1); step();
    chk("R4 slot0 ready after wake", ready_vec[0], 1);
    // R3: scoreboard lookup at insert
    ins(1, 3, 0, 3, 0, 0, 0); step();
    chk("R3 scoreboard-ready source", ready_vec[1], 1);
    // R2: claim marks register not ready
    ins(2, 4, 1, 4, 1, 1, 3); #1 chk("R7 no waiter no err", claim_err, 0); step();
    ins(3, 3, 0, 5, 1, 0, 0); step();
    chk("R2 claimed reg not ready", ready_vec[3], 0);
    // R7: claim with waiter raises error
    ins(5, 4, 1, 4, 1, 1, 3); #1 chk("R7 claim with waiter", claim_err, 1); step();
    // R7/R10: claim and completion same register same cycle
    ins(6, 4, 1, 4, 1, 1, 3); cmp_vld = 1; cmp_tag = 3;
    #1 chk("R7 completion clears waiter", claim_err, 0); step();
    chk("R4 slot3 woken", ready_vec[3], 1);
    ins(7, 3, 0, 4, 1, 0, 0); step();
    chk("R10 claim beats completion", ready_vec[7], 0);
    // R6: out-of-range tags
    ins(0, 35, 0, 4, 1, 1, 40); #1 chk("R6 oor dst no err", claim_err, 0); step();
    chk("R6 oor source ready", ready_vec[0], 1);
    ins(1, 31, 0, 4, 1, 0, 0); step();
    chk("R6 top tracked tag waits", ready_vec[1], 0);
    cmp_vld = 1; cmp_tag = 31; step();
    chk("R6 top tracked tag wakes", ready_vec[1], 1);
    // R5: same-cycle completion and insert
    ins(2, 9, 0, 9, 0, 0, 0); cmp_vld = 1; cmp_tag = 9; step();
    chk("R5 same-cycle completion seen", ready_vec[2], 1);
    // R8: squash
    ins(4, 10, 0, 4, 1, 0, 0); step();
    sq_mask = 8'h10; step();
    chk("R8 squashed not ready", ready_vec[4], 0);
    ins(5, 4, 1, 4, 1, 1, 10); #1 chk("R8 squashed waiter no err", claim_err, 0); step();
    cmp_vld = 1; cmp_tag = 10; #1 chk("R8 squashed not woken", wake_vec[4], 0); step();
    chk("R8 squashed stays out", ready_vec[4], 0);
    // R11: insert beats squash on same slot
    ins(6, 4, 1, 4, 1, 0, 0); sq_mask = 8'h40; step();
    chk("R11 insert over squash", ready_vec[6], 1);

    // Constrained random traffic
    for (int i = 0; i < 3000; i++) begin
      if ($urandom % 2 == 0)
        ins($urandom % E, $urandom % 40, ($urandom % 4) == 0, $urandom % 40,
            ($urandom % 4) == 0, ($urandom % 5) < 3, $urandom % 40);
      if ($urandom % 5 < 2) begin cmp_vld = 1; cmp_tag = TW'($urandom % 40); end
      if ($urandom % 10 == 0) sq_mask = E'($urandom);
      step();
    end

    done = 1;
    summary();
    $finish;
  end
endmodule